// File: doc/BRIEF.md
# Wiper Position Register Controller

This block keeps the position of a 256-step digital potentiometer wiper. The live position sits in a volatile register that drives the wiper. A second 8-bit value models a nonvolatile store and survives a power cycle. A serial front end delivers each finished write transaction as a one-cycle command pulse, carrying a command byte and a data byte. The controller runs one of four operations: load the live position, load the stored value, restore the stored value into the live register, or save the live position into the store.

After each power-up reset, the controller spends a fixed number of clocks recalling the stored value into the live register. Every save into the store is followed by a write-busy window of fixed length. While either of these is running, `busy` is high. Any command that arrives in that time is discarded and sets a sticky flag. Both lengths are parameters counted in clock cycles. Their defaults are 10 µs and 12 ms at 125 MHz, and a bench may scale them down. A registered one-hot tap select follows the live position.

A separate store-reset input stands in for factory programming. It puts the midscale value into the store. The ordinary reset models a power cycle and leaves the store untouched.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While `rst_n` is low, `wiper_code` is 0x00, `busy` is 1, `cmd_dropped` is 0 and only bit 0 of `tap_sel` is set.
- R2: Exactly RECALL_CYC rising edges after `rst_n` is released, `wiper_code` takes the stored value and `busy` falls.
- R3: After `nv_rst_n` has been low, the stored value is 0x80, so the recall that follows sets `wiper_code` to 0x80.
- R4: Command byte 0x11 puts the data byte on `wiper_code` at the next rising edge.
- R5: Command byte 0x21 writes the data byte into the store and leaves `wiper_code` unchanged.
- R6: Command byte 0x61 copies the store into `wiper_code` at the next rising edge, and its data byte is ignored.
- R7: Command byte 0x51 copies `wiper_code` into the store, and its data byte is ignored.
- R8: Commands 0x21 and 0x51 raise `busy` at the next rising edge and hold it high for exactly BUSY_CYC cycles.
- R9: A command that arrives while `busy` is high changes neither register. It sets `cmd_dropped`, which stays set until `rst_n` is next asserted.
- R10: Any other command byte changes neither register and does not set `cmd_dropped`.
- R11: The store keeps its value through an `rst_n` pulse. The recall that follows the pulse restores that value to `wiper_code`.
- R12: `tap_sel` always has exactly one bit set, at index `wiper_code`, and it changes on the same edge as `wiper_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-cycle reset |
| nv_rst_n | input | 1 | Asynchronous active-low store initialisation to midscale |
| cmd_valid | input | 1 | One-cycle pulse marking a completed command |
| cmd_code | input | 8 | Command byte |
| cmd_data | input | 8 | Data byte |
| wiper_code | output | 8 | Live wiper position |
| tap_sel | output | 256 | Registered one-hot tap select |
| busy | output | 1 | Recall or store-busy window is running |
| cmd_dropped | output | 1 | Sticky flag set when a command is discarded |

## Verification
The stored value has no output of its own. A wrong store value therefore shows up only when it is pulled back, either through a 0x61 restore or through the recall after a reset. The bench follows each store operation with one of these, so the error appears one cycle after the restore, or RECALL_CYC cycles after the reset is released. A window counter that is off by one changes the cycle on which `busy` falls, and the bench counts those high cycles directly. A stray register update during a blocked or unknown command appears on `wiper_code` at the very next edge.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [7:0] {
    CMD_SET_LIVE   = 8'h11,
    CMD_SET_SHADOW = 8'h21,
    CMD_SAVE       = 8'h51,
    CMD_RESTORE    = 8'h61
  } wcmd_e;

  typedef struct packed {
    logic load_live;
    logic live_from_shadow;
    logic load_shadow;
    logic shadow_from_live;
  } wop_t;
endpackage

// File: rtl/wiper_countdown.sv
module wiper_countdown #(
  parameter int unsigned LOAD    = 4,
  parameter int unsigned RST_VAL = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);
  localparam int unsigned TOP = (LOAD > RST_VAL) ? LOAD : RST_VAL;
  localparam int W = (TOP < 2) ? 1 : $clog2(TOP + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)                cnt_d = W'(LOAD);
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == W'(1));

  // R8: the window closes right after its last cycle unless restarted
  assert_window_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !active);
endmodule

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
  import wiper_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       blocked,
  output wop_t       op,
  output logic       drop
);
  always_comb begin
    op   = '0;
    drop = 1'b0;
    if (cmd_valid) begin
      if (blocked) begin
        drop = 1'b1;
      end else begin
        case (cmd_code)
          CMD_SET_LIVE:   op.load_live        = 1'b1;
          CMD_SET_SHADOW: op.load_shadow      = 1'b1;
          CMD_RESTORE:    op.live_from_shadow = 1'b1;
          CMD_SAVE:       op.shadow_from_live = 1'b1;
          default:        op                  = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int CODE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CODE_W-1:0]      code_d,
  output logic [(1<<CODE_W)-1:0] sel_q
);
  localparam int TAPS = 1 << CODE_W;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    logic hit;
    assign hit = (code_d == CODE_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[i] <= (i == 0);
      else        sel_q[i] <= hit;
    end
  end
endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl
  import wiper_pkg::*;
#(
  parameter int unsigned RECALL_CYC = 1250,
  parameter int unsigned BUSY_CYC   = 1500000,
  parameter int          CODE_W     = 8,
  parameter logic [7:0]  NV_FACTORY = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   nv_rst_n,
  input  logic                   cmd_valid,
  input  logic [7:0]             cmd_code,
  input  logic [CODE_W-1:0]      cmd_data,
  output logic [CODE_W-1:0]      wiper_code,
  output logic [(1<<CODE_W)-1:0] tap_sel,
  output logic                   busy,
  output logic                   cmd_dropped
);
  logic [CODE_W-1:0] live_q, live_d, shadow_q, shadow_d;
  logic              drop_q, drop_d;
  logic              recall_act, recall_last, store_act, store_last;
  logic              store_start, drop;
  wop_t              op;

  assign busy = recall_act | store_act;

  wiper_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .blocked   (busy),
    .op        (op),
    .drop      (drop)
  );

  assign store_start = op.load_shadow | op.shadow_from_live;

  wiper_countdown #(.LOAD(RECALL_CYC), .RST_VAL(RECALL_CYC)) u_recall (
    .clk (clk), .rst_n (rst_n), .start (1'b0),
    .active (recall_act), .last (recall_last)
  );

  wiper_countdown #(.LOAD(BUSY_CYC), .RST_VAL(0)) u_store (
    .clk (clk), .rst_n (rst_n), .start (store_start),
    .active (store_act), .last (store_last)
  );

  always_comb begin
    live_d = live_q;
    if (recall_last)               live_d = shadow_q;
    else if (op.load_live)         live_d = cmd_data;
    else if (op.live_from_shadow)  live_d = shadow_q;
  end

  always_comb begin
    shadow_d = shadow_q;
    if (op.load_shadow)            shadow_d = cmd_data;
    else if (op.shadow_from_live)  shadow_d = live_q;
  end

  assign drop_d = drop_q | drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      drop_q <= 1'b0;
    end else begin
      live_q <= live_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n)         shadow_q <= NV_FACTORY[CODE_W-1:0];
    else if (store_start)  shadow_q <= shadow_d;
  end

  wiper_tap_decode #(.CODE_W(CODE_W)) u_tap (
    .clk (clk), .rst_n (rst_n), .code_d (live_d), .sel_q (tap_sel)
  );

  assign wiper_code  = live_q;
  assign cmd_dropped = drop_q;

  // R4
  assert_live_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_code == 8'h11) |=> wiper_code == $past(cmd_data));
  // R5
  assert_shadow_keeps_wiper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_code == 8'h21) |=> $stable(wiper_code));
  // R8
  assert_store_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_code == 8'h21 || cmd_code == 8'h51)) |=> busy);
  // R9
  assert_blocked_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> cmd_dropped);
  assert_drop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dropped |=> cmd_dropped);
  // R10
  assert_unknown_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_code != 8'h11 && cmd_code != 8'h21 &&
     cmd_code != 8'h51 && cmd_code != 8'h61)
    |=> ($stable(wiper_code) && !busy && $stable(cmd_dropped)));
  // R12
  assert_tap_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper_code]);
endmodule

// File: tb/sim_wiper_nv_ctrl.sv
module sim_wiper_nv_ctrl;
  localparam int unsigned RC = 20;
  localparam int unsigned BC = 50;

  logic         clk = 1'b0;
  logic         rst_n, nv_rst_n, cmd_valid;
  logic [7:0]   cmd_code, cmd_data, wiper_code;
  logic [255:0] tap_sel;
  logic         busy, cmd_dropped;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  wiper_nv_ctrl #(.RECALL_CYC(RC), .BUSY_CYC(BC)) u0 (
    .clk (clk), .rst_n (rst_n), .nv_rst_n (nv_rst_n),
    .cmd_valid (cmd_valid), .cmd_code (cmd_code), .cmd_data (cmd_data),
    .wiper_code (wiper_code), .tap_sel (tap_sel),
    .busy (busy), .cmd_dropped (cmd_dropped)
  );

  // {command, data, expected wiper}
  localparam logic [23:0] VEC [10] = '{
    {8'h11, 8'h3C, 8'h3C},   // R4
    {8'h21, 8'hA5, 8'h3C},   // R5
    {8'h61, 8'h00, 8'hA5},   // R6
    {8'h11, 8'h07, 8'h07},   // R4
    {8'h51, 8'hFF, 8'h07},   // R7 save
    {8'h11, 8'hFE, 8'hFE},   // R4
    {8'h61, 8'h33, 8'h07},   // R6 R7 restore saved value
    {8'h99, 8'h55, 8'h07},   // R10
    {8'h11, 8'hFF, 8'hFF},   // R4 top tap
    {8'h11, 8'h00, 8'h00}    // R4 bottom tap
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic power_cycle(input bit factory);
    @(negedge clk);
    rst_n = 1'b0;
    if (factory) nv_rst_n = 1'b0;
    @(negedge clk);
    check(wiper_code == 8'h00, "R1 wiper", wiper_code, 0);
    check(busy == 1'b1 && cmd_dropped == 1'b0, "R1 flags", {busy, cmd_dropped}, 2);
    check(tap_sel == 256'd1, "R1 tap", $countones(tap_sel), 1);
    rst_n = 1'b1; nv_rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cmd_valid = 1'b0; cmd_code = '0; cmd_data = '0;
    rst_n = 1'b0; nv_rst_n = 1'b0;
    #20;
    power_cycle(1'b1);
    // reset released at negedge: RC-1 edges still busy, RC-th loads
    for (int i = 0; i < int'(RC) - 1; i++) @(negedge clk);
    check(busy == 1'b1 && wiper_code == 8'h00, "R2 before end", wiper_code, 0);
    @(negedge clk);
    check(busy == 1'b0, "R2 busy falls", busy, 0);
    check(wiper_code == 8'h80, "R3 midscale", wiper_code, 8'h80);

    for (int v = 0; v < 10; v++) begin
      send(VEC[v][23:16], VEC[v][15:8]);
      check(wiper_code == VEC[v][7:0], $sformatf("R4-R7 vec %0d wiper", v),
            wiper_code, VEC[v][7:0]);
      check(tap_sel[wiper_code] && $countones(tap_sel) == 1,
            $sformatf("R12 vec %0d", v), $countones(tap_sel), 1);
      wait_idle();
    end
    check(cmd_dropped == 1'b0, "R10 no drop", cmd_dropped, 0);

    // R8 window length, R9 blocking
    send(8'h21, 8'h44);
    begin
      int n = 1;
      send(8'h11, 8'h99);
      check(wiper_code == 8'h00, "R9 blocked write", wiper_code, 0);
      check(cmd_dropped == 1'b1, "R9 drop set", cmd_dropped, 1);
      n += 2;
      while (busy) begin
        n++;
        @(negedge clk);
      end
      n--;
      check(n == int'(BC), "R8 busy length", n, BC);
    end
    send(8'h99, 8'h00);
    check(cmd_dropped == 1'b1, "R9 sticky", cmd_dropped, 1);

    // R11 store survives power cycle; command during recall dropped
    power_cycle(1'b0);
    send(8'h11, 8'h12);
    check(cmd_dropped == 1'b1 && wiper_code == 8'h00, "R9 drop during recall",
          wiper_code, 0);
    wait_idle();
    check(wiper_code == 8'h44, "R11 recall", wiper_code, 8'h44);
    check(tap_sel[8'h44] == 1'b1, "R12 after recall", $countones(tap_sel), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule